// File: doc/BRIEF.md
# Serial Configuration Memory Readout

This block is the read side of a bit-serial configuration store that feeds a programmable logic device which clocks its own configuration in. A word-organized array is loaded through a simple synchronous write port. When the device is selected and its output is enabled, every strobe on the serial clock input moves the stream forward by one bit. An address counter and a bit-in-word counter walk the array, and the current bit appears on a data output that can be put in high impedance.

The counters can be held to one quarter of the array, so that one device can hold four separate images. When the stream runs past the last address of the active range, the data driver turns off. A cascade-select output then goes low so that a second device, whose chip select it drives, can take over the data line. After an asynchronous power-on reset is released, a fixed settling count runs before the ready flag rises. A mode input puts the block into programming mode, in which it drives no configuration data.

Top module: `cfg_prom_rd`

## Requirements
- R1: While rst_ni is low, and for PWRUP_CYC rising clock edges after it is released, ready_o is 0, data_oe_o is 0 and casc_no is 1. ready_o is 1 after edge PWRUP_CYC and stays 1 until the next power-on reset.
- R2: While ser_en_i is 1, a low oe_rst_i turns off data_oe_o at once. On each clock edge it returns both counters to the start of the active range. After oe_rst_i returns high, the first bit presented is the MSB of the first word of that range.
- R3: While cs_ni is 1, data_oe_o is 0 and dclk_i strobes are ignored. When cs_ni returns low, the stream continues from the bit at which it stopped.
- R4: While ser_en_i, oe_rst_i and ready_o are 1 and cs_ni is 0, data_oe_o is 1 and data_o carries the current bit. Each clock edge with dclk_i = 1 moves to the next bit. Words are sent MSB first, and after the LSB the next address follows.
- R5: With page_en_i = 1, the array splits into four pages of DEPTH/4 words, and page_sel_i = n selects words n*DEPTH/4 to (n+1)*DEPTH/4-1. Reading starts at that page's base and ends after the LSB of its last word.
- R6: With page_en_i = 0, the whole array from word 0 to word DEPTH-1 is read, whatever the value of page_sel_i.
- R7: After the LSB of the last word of the active range has been consumed, data_oe_o is 0 and further dclk_i strobes have no effect. casc_no is 0 while cs_ni is 0 and oe_rst_i is 1.
- R8: Once the range is exhausted, casc_no equals cs_ni while oe_rst_i stays high. It goes to 1 when oe_rst_i goes low, and a new read then begins from the start of the range.
- R9: While ser_en_i is 0, data_oe_o is 0 and casc_no is 1. dclk_i, cs_ni, oe_rst_i, page_en_i and page_sel_i have no effect on the counters, so readout resumes at the same bit when ser_en_i returns high.
- R10: A clock edge with wr_en_i = 1 stores wr_data_i at word wr_addr_i. Later reads of that word return the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| wr_en_i | input | 1 | Preload write strobe |
| wr_addr_i | input | $clog2(DEPTH) | Preload word address |
| wr_data_i | input | WORD_W | Preload word data |
| ser_en_i | input | 1 | 1: configuration readout mode, 0: programming mode |
| cs_ni | input | 1 | Chip select, active low |
| oe_rst_i | input | 1 | 1: output enable, 0: counter reset |
| dclk_i | input | 1 | Serial clock strobe, one bit per cycle it is high |
| page_en_i | input | 1 | Confine reading to one quarter of the array |
| page_sel_i | input | 2 | Selected quarter |
| data_o | output | 1 | Current serial bit |
| data_oe_o | output | 1 | Driver enable for data_o |
| casc_no | output | 1 | Cascade select for the next device, active low |
| ready_o | output | 1 | Power-up settling complete |

## Verification
The assertions check the output-enable rules on every cycle: no drive before ready, under counter reset, while deselected or in programming mode, and never together with a low cascade select. They also check that the presented bit holds still when no strobe, write or clear can move it. The order of the bits, the word and page boundaries, resumption after deselection or programming mode, and the hold-follow-release sequence of the cascade output are shown only by the bench's scenarios. There a scoreboard predicts every strobed bit from a shadow copy of the array.

// File: rtl/cfg_prom_pkg.sv
package cfg_prom_pkg;
  localparam int unsigned NUM_PAGES = 4;
  localparam int unsigned PSEL_W    = $clog2(NUM_PAGES);
endpackage

// File: rtl/prom_pwrup.sv
module prom_pwrup #(
  parameter int unsigned CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ready_o
);
  localparam int unsigned CW = (CYC > 1) ? $clog2(CYC) : 1;

  logic [CW-1:0] cnt_q;
  logic          rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (!rdy_q) begin
      if (cnt_q == CW'(CYC - 1)) rdy_q <= 1'b1;
      else                       cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready_o = rdy_q;
endmodule

// File: rtl/prom_store.sv
module prom_store #(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned BW = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  input  logic [BW-1:0]     rd_bit_i,
  output logic              rd_bit_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [WORD_W-1:0] word;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  // MSB leaves first
  assign word     = mem_q[rd_addr_i];
  assign rd_bit_o = word[BW'(WORD_W - 1) - rd_bit_i];
endmodule

// File: rtl/prom_seq.sv
module prom_seq
  import cfg_prom_pkg::*;
#(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned AW  = $clog2(DEPTH),
  localparam int unsigned BW  = $clog2(WORD_W),
  localparam int unsigned PAW = AW - PSEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ready_i,
  input  logic              ser_en_i,
  input  logic              cs_ni,
  input  logic              oe_i,
  input  logic              dclk_i,
  input  logic              page_en_i,
  input  logic [PSEL_W-1:0] page_sel_i,
  output logic [AW-1:0]     addr_o,
  output logic [BW-1:0]     bit_o,
  output logic              done_o
);
  logic [AW-1:0] base, last;
  logic [AW-1:0] addr_q;
  logic [BW-1:0] bit_q;
  logic          done_q;
  logic          clr, adv;

  always_comb begin
    base = '0;
    last = '1;
    if (page_en_i) begin
      base = {page_sel_i, {PAW{1'b0}}};
      last = {page_sel_i, {PAW{1'b1}}};
    end
  end

  // reset/OE acts only in readout mode
  assign clr = !ready_i || (ser_en_i && !oe_i);
  assign adv = ready_i && ser_en_i && oe_i && !cs_ni && dclk_i && !done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else if (clr) begin
      addr_q <= base;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else if (adv) begin
      if (bit_q == BW'(WORD_W - 1)) begin
        bit_q <= '0;
        if (addr_q == last) done_q <= 1'b1;
        else                addr_q <= addr_q + 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign addr_o = addr_q;
  assign bit_o  = bit_q;
  assign done_o = done_q;
endmodule

// File: rtl/cfg_prom_rd.sv
module cfg_prom_rd
  import cfg_prom_pkg::*;
#(
  parameter int unsigned WORD_W    = 8,
  parameter int unsigned DEPTH     = 64,
  parameter int unsigned PWRUP_CYC = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned BW = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              ser_en_i,
  input  logic              cs_ni,
  input  logic              oe_rst_i,
  input  logic              dclk_i,
  input  logic              page_en_i,
  input  logic [PSEL_W-1:0] page_sel_i,
  output logic              data_o,
  output logic              data_oe_o,
  output logic              casc_no,
  output logic              ready_o
);
  logic          ready;
  logic [AW-1:0] addr;
  logic [BW-1:0] bit_idx;
  logic          done;
  logic          rd_bit;
  logic          active;

  prom_pwrup #(.CYC(PWRUP_CYC)) u_pwrup (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ready_o(ready)
  );

  prom_seq #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ready_i   (ready),
    .ser_en_i  (ser_en_i),
    .cs_ni     (cs_ni),
    .oe_i      (oe_rst_i),
    .dclk_i    (dclk_i),
    .page_en_i (page_en_i),
    .page_sel_i(page_sel_i),
    .addr_o    (addr),
    .bit_o     (bit_idx),
    .done_o    (done)
  );

  prom_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk_i    (clk_i),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .rd_addr_i(addr),
    .rd_bit_i (bit_idx),
    .rd_bit_o (rd_bit)
  );

  assign active    = ready && ser_en_i && oe_rst_i && !cs_ni;
  assign data_o    = rd_bit;
  assign data_oe_o = active && !done;
  assign casc_no   = !(active && done);
  assign ready_o   = ready;
endmodule

// File: rtl/cfg_prom_rd_chk.sv
module cfg_prom_rd_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_en_i,
  input logic ser_en_i,
  input logic cs_ni,
  input logic oe_rst_i,
  input logic dclk_i,
  input logic data_o,
  input logic data_oe_o,
  input logic casc_no,
  input logic ready_o
);
  a_r1_quiet_until_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (!data_oe_o && casc_no));

  a_r1_ready_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  a_r2_reset_floats: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_en_i && !oe_rst_i) |-> !data_oe_o);

  a_r3_deselect_floats: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !data_oe_o);

  a_r3_deselect_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && ser_en_i && oe_rst_i && cs_ni && !wr_en_i) |=> $stable(data_o));

  a_r4_no_strobe_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && ser_en_i && oe_rst_i && !dclk_i && !wr_en_i) |=> $stable(data_o));

  a_r7_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(data_oe_o && !casc_no));

  a_r9_prog_mode_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_en_i |-> (!data_oe_o && casc_no));
endmodule

bind cfg_prom_rd cfg_prom_rd_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .ser_en_i (ser_en_i),
  .cs_ni    (cs_ni),
  .oe_rst_i (oe_rst_i),
  .dclk_i   (dclk_i),
  .data_o   (data_o),
  .data_oe_o(data_oe_o),
  .casc_no  (casc_no),
  .ready_o  (ready_o)
);

// File: tb/tb_cfg_prom_rd.sv
`timescale 1ns/1ps
module tb_cfg_prom_rd;
  localparam int WW = 8;
  localparam int DEPTH = 64;
  localparam int PWR = 16;
  localparam int AW = $clog2(DEPTH);
  localparam int PG = DEPTH / 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [WW-1:0] wr_data_i = '0;
  logic          ser_en_i = 1'b1;
  logic          cs_ni = 1'b1;
  logic          oe_rst_i = 1'b0;
  logic          dclk_i = 1'b0;
  logic          page_en_i = 1'b0;
  logic [1:0]    page_sel_i = 2'd0;
  logic          data_o, data_oe_o, casc_no, ready_o;

  cfg_prom_rd #(.WORD_W(WW), .DEPTH(DEPTH), .PWRUP_CYC(PWR)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .ser_en_i(ser_en_i), .cs_ni(cs_ni), .oe_rst_i(oe_rst_i),
    .dclk_i(dclk_i), .page_en_i(page_en_i), .page_sel_i(page_sel_i),
    .data_o(data_o), .data_oe_o(data_oe_o), .casc_no(casc_no), .ready_o(ready_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done_run = 0;
  string cur_req = "R4";
  bit exp_q[$];
  logic [WW-1:0] shadow [DEPTH];
  int ea, eb;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_run) begin
      done_run = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // monitor: compare each strobed bit against the scoreboard
  always @(negedge clk) begin
    if (dclk_i && exp_q.size() > 0) begin
      bit e;
      e = exp_q.pop_front();
      chk(data_oe_o === 1'b1, cur_req, "data_oe during strobe", int'(data_oe_o), 1);
      chk(data_o === e, cur_req, "serial bit", int'(data_o), int'(e));
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic pulse(input bit expect_data);
    dclk_i = 1'b1;
    if (expect_data) begin
      exp_q.push_back(shadow[ea][WW-1-eb]);
      eb++;
      if (eb == WW) begin eb = 0; ea++; end
    end
    tick();
    dclk_i = 1'b0;
  endtask

  task automatic rd(input int n);
    for (int i = 0; i < n; i++) pulse(1'b1);
  endtask

  task automatic wr(input int a, input logic [WW-1:0] d);
    wr_en_i = 1'b1; wr_addr_i = AW'(a); wr_data_i = d;
    tick();
    wr_en_i = 1'b0;
    shadow[a] = d;
  endtask

  task automatic restart(input int base);
    oe_rst_i = 1'b0;
    tick();
    oe_rst_i = 1'b1;
    ea = base; eb = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    #20;
    chk(ready_o === 1'b0, "R1", "ready in reset", int'(ready_o), 0);
    chk(data_oe_o === 1'b0, "R1", "data_oe in reset", int'(data_oe_o), 0);
    chk(casc_no === 1'b1, "R1", "casc in reset", int'(casc_no), 1);
    @(posedge clk); #2;
    rst_ni = 1'b1;
    repeat (PWR - 1) tick();
    chk(ready_o === 1'b0, "R1", "ready one edge early", int'(ready_o), 0);
    tick();
    chk(ready_o === 1'b1, "R1", "ready after settling", int'(ready_o), 1);

    for (int i = 0; i < DEPTH; i++) wr(i, WW'((i * 37 + 11) & 255));

    // R6: whole range, page_sel ignored
    page_sel_i = 2'd3; page_en_i = 1'b0;
    oe_rst_i = 1'b1; cs_ni = 1'b0; ea = 0; eb = 0;
    #1;
    chk(data_oe_o === 1'b1, "R4", "driver on when selected", int'(data_oe_o), 1);
    cur_req = "R6"; rd(20);

    // R3: deselect freezes stream
    cs_ni = 1'b1; #1;
    chk(data_oe_o === 1'b0, "R3", "driver off when deselected", int'(data_oe_o), 0);
    for (int i = 0; i < 3; i++) pulse(1'b0);
    cs_ni = 1'b0;
    cur_req = "R3"; rd(8);

    // R9: programming mode
    ser_en_i = 1'b0; #1;
    chk(data_oe_o === 1'b0, "R9", "driver off in programming mode", int'(data_oe_o), 0);
    chk(casc_no === 1'b1, "R9", "casc high in programming mode", int'(casc_no), 1);
    pulse(1'b0); pulse(1'b0);
    page_en_i = 1'b1; cs_ni = 1'b1; oe_rst_i = 1'b0; tick();
    oe_rst_i = 1'b1; cs_ni = 1'b0; page_en_i = 1'b0; ser_en_i = 1'b1;
    cur_req = "R9"; rd(8);

    // R2: counter reset
    oe_rst_i = 1'b0; #1;
    chk(data_oe_o === 1'b0, "R2", "driver off under reset", int'(data_oe_o), 0);
    tick();
    oe_rst_i = 1'b1; ea = 0; eb = 0;
    cur_req = "R2"; rd(8);

    // R7: read to the end of the array
    cur_req = "R4"; rd(DEPTH * WW - 8 - 1);
    chk(casc_no === 1'b1, "R7", "casc before last bit", int'(casc_no), 1);
    cur_req = "R7"; rd(1);
    #1;
    chk(data_oe_o === 1'b0, "R7", "driver off after last bit", int'(data_oe_o), 0);
    chk(casc_no === 1'b0, "R7", "casc low after last bit", int'(casc_no), 0);
    pulse(1'b0); pulse(1'b0);
    chk(casc_no === 1'b0, "R7", "casc held low", int'(casc_no), 0);
    chk(data_oe_o === 1'b0, "R7", "driver stays off", int'(data_oe_o), 0);

    // R8: follow then release
    cs_ni = 1'b1; #1;
    chk(casc_no === 1'b1, "R8", "casc follows cs high", int'(casc_no), 1);
    cs_ni = 1'b0; #1;
    chk(casc_no === 1'b0, "R8", "casc follows cs low", int'(casc_no), 0);
    oe_rst_i = 1'b0; #1;
    chk(casc_no === 1'b1, "R8", "casc released by oe low", int'(casc_no), 1);
    tick();
    oe_rst_i = 1'b1; #1;
    chk(casc_no === 1'b1, "R8", "casc high on new read", int'(casc_no), 1);
    chk(data_oe_o === 1'b1, "R8", "driver back on new read", int'(data_oe_o), 1);
    ea = 0; eb = 0;
    cur_req = "R8"; rd(4);

    // R10 + R5: overwrite, then paged read of page 2
    wr(2 * PG, 8'hA5);
    page_en_i = 1'b1; page_sel_i = 2'd2;
    restart(2 * PG);
    cur_req = "R10"; rd(WW);
    cur_req = "R5"; rd(PG * WW - WW - 1);
    chk(casc_no === 1'b1, "R5", "casc before page end", int'(casc_no), 1);
    rd(1);
    #1;
    chk(casc_no === 1'b0, "R5", "casc low at page end", int'(casc_no), 0);
    chk(data_oe_o === 1'b0, "R5", "driver off at page end", int'(data_oe_o), 0);

    page_sel_i = 2'd1;
    restart(PG);
    rd(12);

    // R1: power-on reset again
    rst_ni = 1'b0; #1;
    chk(ready_o === 1'b0, "R1", "ready drops on reset", int'(ready_o), 0);
    chk(data_oe_o === 1'b0, "R1", "driver off on reset", int'(data_oe_o), 0);

    tick();
    finish_run();
  end
endmodule